// File: doc/BRIEF.md
# Blanking-Aware Video Memory Write Pacer

This block sits between a CPU and a retro video display processor and works out, purely from the CPU clock, where the beam is in the frame. It counts clock cycles within a scanline and scanlines within a frame. It reports whether the beam is in the visible picture or in vertical blanking, and raises a frame interrupt when the picture ends.

Video memory writes cannot follow each other at any speed. While the picture is being drawn, successive writes need a wide spacing. During vertical blanking, a much narrower one is enough. The pacer measures the time since the last accepted write and drops `ready` until the spacing required in the current region has passed. An accepted write is passed on to the video memory port. A write that comes while `ready` is low is dropped and sets a sticky violation flag.

A 50/60 Hz select picks the frame height. A change to it is applied only where one frame ends and the next begins.

Top module: `vram_pacer`

## Requirements
- R1: After reset, `frame_irq`, `in_blank` and `violation` are 0 and `ready` is 1. The raster starts at cycle 0 of line 0, the first visible line. The reset also loads the geometry from `mode_60`.
- R2: A scanline lasts 228 clock cycles. Lines 0 to 191 are visible. With N counted as clock edges since reset release, `in_blank` first becomes 1 after edge 192*228.
- R3: A frame has 313 lines when the latched geometry is 50 Hz (`mode_60`=0) and 262 lines when it is 60 Hz (`mode_60`=1). `in_blank` returns to 0 after edge 313*228 or 262*228 respectively.
- R4: `frame_irq` is set on the same edge at which `in_blank` rises, which is when the last visible line ends.
- R5: `frame_irq` stays set until a one-cycle pulse on `irq_ack` clears it. The flag is set again in every frame. Setting takes priority over an acknowledge in the same cycle.
- R6: In the visible region, an accepted write at edge A makes `ready` 0 up to edge A+27. `ready` is 1 again after edge A+28, so the next write can be accepted at edge A+29.
- R7: In blanking, an accepted write at edge A makes `ready` 0 up to edge A+6. `ready` is 1 again after edge A+7.
- R8: The required spacing is the one for the region the new write falls in. A write made in the visible region just before blanking allows a blanking write 8 cycles later.
- R9: A write strobe while `ready` is 0 is not accepted: `vram_we` stays 0 and the spacing timer is not restarted. It also sets `violation`, which stays at 1 until reset.
- R10: A change of `mode_60` during a frame does not alter that frame's length. It takes effect from the next frame.
- R11: An accepted write drives `vram_we`=1 in the same cycle, with `vram_wdata` equal to `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_60 | input | 1 | Geometry select: 1 = 262-line frame, 0 = 313-line frame |
| wr_stb | input | 1 | CPU write request, one cycle per write |
| wr_data | input | DW | CPU write data |
| irq_ack | input | 1 | One-cycle acknowledge of the frame interrupt |
| frame_irq | output | 1 | Frame interrupt flag |
| in_blank | output | 1 | Beam is in vertical blanking |
| ready | output | 1 | A write now would be accepted |
| violation | output | 1 | Sticky: a write came while ready was low |
| vram_we | output | 1 | Accepted write strobe toward video memory |
| vram_wdata | output | DW | Data of the accepted write |

## Verification
The hardest case to reach is a write pair that straddles the change from picture to blanking. The first write must be accepted in the last few cycles of line 191, and the second must then be judged by the short blanking rule. The bench counts clock edges from reset release itself and places the first strobe three edges before the blanking edge in a 60 Hz frame. Within the same frame it changes `mode_60` and checks that blanking still ends at the 262-line boundary.

// File: rtl/vram_pacer_pkg.sv
package vram_pacer_pkg;

    typedef enum logic {
        REG_ACTIVE = 1'b0,
        REG_BLANK  = 1'b1
    } region_t;

    typedef enum logic {
        GEOM_50 = 1'b0,
        GEOM_60 = 1'b1
    } geom_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic geom_t geom_of(input logic sel60);
        return sel60 ? GEOM_60 : GEOM_50;
    endfunction

endpackage

// File: rtl/pacer_raster.sv
module pacer_raster
    import vram_pacer_pkg::*;
#(
    parameter int LINE_CYC  = 228,
    parameter int ACT_LINES = 192,
    parameter int LINES_50  = 313,
    parameter int LINES_60  = 262,
    parameter int CW        = 8,
    parameter int LW        = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_60,
    output logic [CW-1:0] cyc,
    output logic [LW-1:0] line,
    output region_t       region,
    output logic          blank_start,
    output logic          frame_end
);
    localparam logic [CW-1:0] CYC_LAST  = CW'(LINE_CYC - 1);
    localparam logic [LW-1:0] LAST_50   = LW'(LINES_50 - 1);
    localparam logic [LW-1:0] LAST_60   = LW'(LINES_60 - 1);
    localparam logic [LW-1:0] ACT_LAST  = LW'(ACT_LINES - 1);
    localparam logic [LW-1:0] ACT_COUNT = LW'(ACT_LINES);

    geom_t         geom;
    logic          line_end;
    logic [LW-1:0] last_line;

    assign line_end    = (cyc == CYC_LAST);
    assign last_line   = (geom == GEOM_60) ? LAST_60 : LAST_50;
    assign frame_end   = line_end && (line == last_line);
    assign blank_start = line_end && (line == ACT_LAST);
    assign region      = (line >= ACT_COUNT) ? REG_BLANK : REG_ACTIVE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc  <= '0;
            line <= '0;
            geom <= geom_of(mode_60);
        end else if (line_end) begin
            cyc <= '0;
            if (frame_end) begin
                line <= '0;
                geom <= geom_of(mode_60);
            end else begin
                line <= line + 1'b1;
            end
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    a_r2_line_wrap: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (cyc == '0));

    a_r3_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (line == '0));

    a_r10_geom_held: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(geom));

endmodule

// File: rtl/pacer_irq.sv
module pacer_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic ack,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)            irq <= 1'b0;
        else if (set_pulse) irq <= 1'b1;
        else if (ack)       irq <= 1'b0;
    end

    a_r4_irq_on_blank: assert property (@(posedge clk) disable iff (rst)
        set_pulse |=> irq);

    a_r5_irq_held: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq);

    a_r5_irq_ack: assert property (@(posedge clk) disable iff (rst)
        (ack && !set_pulse) |=> !irq);

endmodule

// File: rtl/pacer_spacer.sv
module pacer_spacer
    import vram_pacer_pkg::*;
#(
    parameter int GAP_ACT = 29,
    parameter int GAP_BLK = 8,
    parameter int GW      = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  region_t region,
    input  logic    wr_stb,
    output logic    ready,
    output logic    accept,
    output logic    violation
);
    localparam logic [GW-1:0] SAT  = GW'(max_int(GAP_ACT, GAP_BLK));
    localparam logic [GW-1:0] NACT = GW'(GAP_ACT);
    localparam logic [GW-1:0] NBLK = GW'(GAP_BLK);

    logic [GW-1:0] gap;
    logic [GW-1:0] need;

    assign need   = (region == REG_BLANK) ? NBLK : NACT;
    assign ready  = (gap >= need);
    assign accept = wr_stb && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= SAT;
            violation <= 1'b0;
        end else begin
            if (accept)          gap <= GW'(1);
            else if (gap < SAT)  gap <= gap + 1'b1;
            if (wr_stb && !ready) violation <= 1'b1;
        end
    end

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        violation |=> violation);

    a_r9_early_flagged: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !ready) |=> violation);

    a_r6_stall_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);

    a_r9_gap_kept: assert property (@(posedge clk) disable iff (rst)
        (!accept && gap < SAT) |=> (gap == $past(gap) + 1'b1));

endmodule

// File: rtl/vram_pacer.sv
module vram_pacer
    import vram_pacer_pkg::*;
#(
    parameter int DW        = 8,
    parameter int LINE_CYC  = 228,
    parameter int ACT_LINES = 192,
    parameter int LINES_50  = 313,
    parameter int LINES_60  = 262,
    parameter int GAP_ACT   = 29,
    parameter int GAP_BLK   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_60,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          irq_ack,
    output logic          frame_irq,
    output logic          in_blank,
    output logic          ready,
    output logic          violation,
    output logic          vram_we,
    output logic [DW-1:0] vram_wdata
);
    localparam int CW = $clog2(LINE_CYC);
    localparam int LW = $clog2(max_int(LINES_50, LINES_60));
    localparam int GW = $clog2(max_int(GAP_ACT, GAP_BLK) + 1);

    logic [CW-1:0] cyc;
    logic [LW-1:0] line;
    region_t       region;
    logic          blank_start;
    logic          frame_end;
    logic          accept;

    pacer_raster #(
        .LINE_CYC (LINE_CYC),
        .ACT_LINES(ACT_LINES),
        .LINES_50 (LINES_50),
        .LINES_60 (LINES_60),
        .CW       (CW),
        .LW       (LW)
    ) u_raster (
        .clk        (clk),
        .rst        (rst),
        .mode_60    (mode_60),
        .cyc        (cyc),
        .line       (line),
        .region     (region),
        .blank_start(blank_start),
        .frame_end  (frame_end)
    );

    pacer_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_pulse(blank_start),
        .ack      (irq_ack),
        .irq      (frame_irq)
    );

    pacer_spacer #(
        .GAP_ACT(GAP_ACT),
        .GAP_BLK(GAP_BLK),
        .GW     (GW)
    ) u_spacer (
        .clk      (clk),
        .rst      (rst),
        .region   (region),
        .wr_stb   (wr_stb),
        .ready    (ready),
        .accept   (accept),
        .violation(violation)
    );

    assign in_blank   = (region == REG_BLANK);
    assign vram_we    = accept;
    assign vram_wdata = wr_data;

    a_r11_we_needs_ready: assert property (@(posedge clk) disable iff (rst)
        vram_we |-> (ready && wr_stb));

    a_r4_irq_with_blank: assert property (@(posedge clk) disable iff (rst)
        $rose(in_blank) |-> frame_irq);

    a_r2_blank_edge_at_line_end: assert property (@(posedge clk) disable iff (rst)
        $rose(in_blank) |-> ($past(cyc) == CW'(LINE_CYC - 1) && cyc == '0));

endmodule

// File: tb/sim_vram_pacer.sv
`timescale 1ns/1ps
module sim_vram_pacer;
    localparam int DW = 8;
    localparam int LC = 228;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_60 = 1'b0;
    logic          wr_stb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          irq_ack = 1'b0;
    logic          frame_irq, in_blank, ready, violation, vram_we;
    logic [DW-1:0] vram_wdata;

    int edges = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    vram_pacer #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .mode_60(mode_60), .wr_stb(wr_stb),
        .wr_data(wr_data), .irq_ack(irq_ack), .frame_irq(frame_irq),
        .in_blank(in_blank), .ready(ready), .violation(violation),
        .vram_we(vram_we), .vram_wdata(vram_wdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", req, edges, act, exp);
        end
    endtask

    task automatic wait_until(input int n);
        while (edges < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset(input bit m);
        mode_60 = m;
        rst = 1'b1;
        wr_stb = 1'b0;
        irq_ack = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // strobe is sampled at edge a; we/wdata observed before that edge
    task automatic write_at(input int a, input logic [DW-1:0] d,
                            output logic we, output logic [DW-1:0] wd);
        wait_until(a - 1);
        wr_stb = 1'b1;
        wr_data = d;
        #1;
        we = vram_we;
        wd = vram_wdata;
        wait_until(a);
        wr_stb = 1'b0;
    endtask

    task automatic t_reset_state();
        logic we;
        logic [DW-1:0] wd;
        do_reset(1'b0);
        check(frame_irq == 0, "R1 irq", frame_irq, 0);
        check(in_blank == 0, "R1 blank", in_blank, 0);
        check(ready == 1, "R1 ready", ready, 1);
        check(violation == 0, "R1 violation", violation, 0);
        write_at(1, 8'h5A, we, wd);
        check(we == 1, "R1 first write accepted", we, 1);
    endtask

    task automatic t_active_spacing();
        logic we;
        logic [DW-1:0] wd;
        do_reset(1'b0);
        write_at(5, 8'hC3, we, wd);
        check(we == 1, "R11 we", we, 1);
        check(wd == 8'hC3, "R11 wdata", wd, 8'hC3);
        write_at(10, 8'h11, we, wd);
        check(we == 0, "R9 early write dropped", we, 0);
        #1;
        check(violation == 1, "R9 violation set", violation, 1);
        wait_until(5 + 27);
        check(ready == 0, "R6 ready low at A+27", ready, 0);
        wait_until(5 + 28);
        check(ready == 1, "R6 ready high at A+28", ready, 1);
        check(violation == 1, "R9 violation sticky", violation, 1);
        write_at(5 + 29, 8'h7E, we, wd);
        check(we == 1, "R6 write accepted at A+29", we, 1);
        check(wd == 8'h7E, "R11 wdata 2", wd, 8'h7E);
    endtask

    task automatic t_frame50();
        do_reset(1'b0);
        wait_until(192 * LC - 1);
        check(in_blank == 0, "R2 visible before line 192", in_blank, 0);
        check(frame_irq == 0, "R4 irq low before blanking", frame_irq, 0);
        wait_until(192 * LC);
        check(in_blank == 1, "R2 blank at line 192", in_blank, 1);
        check(frame_irq == 1, "R4 irq at blank start", frame_irq, 1);
        wait_until(313 * LC - 1);
        check(in_blank == 1, "R3 50Hz still blank", in_blank, 1);
        check(frame_irq == 1, "R5 irq held without ack", frame_irq, 1);
        wait_until(313 * LC);
        check(in_blank == 0, "R3 50Hz frame end", in_blank, 0);
        irq_ack = 1'b1;
        wait_until(313 * LC + 1);
        irq_ack = 1'b0;
        check(frame_irq == 0, "R5 ack clears", frame_irq, 0);
    endtask

    task automatic t_frame60();
        logic we;
        logic [DW-1:0] wd;
        int a;
        int b;
        do_reset(1'b1);
        wait_until(1000);
        mode_60 = 1'b0;
        a = 192 * LC - 3;
        write_at(a, 8'h21, we, wd);
        check(we == 1, "R8 late visible write", we, 1);
        wait_until(a + 6);
        check(ready == 0, "R8 ready low at A+6", ready, 0);
        check(in_blank == 1, "R8 now blank", in_blank, 1);
        wait_until(a + 7);
        check(ready == 1, "R8 blank rule applied", ready, 1);
        b = a + 8;
        write_at(b, 8'h42, we, wd);
        check(we == 1, "R7 blank write", we, 1);
        wait_until(b + 6);
        check(ready == 0, "R7 ready low at B+6", ready, 0);
        wait_until(b + 7);
        check(ready == 1, "R7 ready high at B+7", ready, 1);
        wait_until(262 * LC - 1);
        check(in_blank == 1, "R3 60Hz still blank", in_blank, 1);
        wait_until(262 * LC);
        check(in_blank == 0, "R10 60Hz frame kept after mode change", in_blank, 0);
    endtask

    initial begin
        t_reset_state();
        t_active_spacing();
        t_frame50();
        t_frame60();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(190000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule